// File: doc/BRIEF.md
# Triple-XOR Configuration Store with Serial Programming

This block keeps a 52-bit configuration word for an angle sensor and exposes the decoded parameters. The zero offset, the mode nibble and the error mask each exist in three copies. The effective value of each is the XOR of its three copies. Because the backing fuses can only go from 0 to 1, this gives each parameter up to three rewrites over the life of the part. The CRC seed, the two factory bits and the test nibble are held once.

A programming input is sampled in the first clock after reset. If it is low, the block is in normal mode. It copies the fuse contents into its working register once and then ignores serial traffic. If it is high, the operation code sampled at the same moment chooses one of four programming operations, and that choice lasts until the next reset:
- idle;
- a temporary write into the working register;
- a write that also burns fuses;
- a readback that first reloads the working register from the fuses.

Serial bits arrive LSB first, one per rising edge of the serial clock.

Top module: `xor3_cfg_store`

## Requirements
- R1: `prog_pin` and `op_sel` are captured in the first clock after reset release. Later changes on them have no effect until the next reset.
- R2: With `prog_pin` low at startup, the working register is loaded from `fuse_rd`. Serial traffic then changes nothing, and `burn_stb` stays low.
- R3: Serial bits fill the working register LSB first, bit index 0 through 51, one per rising edge of `ser_clk`. Edges after the 52nd are ignored.
- R4: Operation code 01 (temporary write) stores each serial bit and never raises `burn_stb`.
- R5: Operation code 10 (burning write) stores each serial bit. When the bit is 1 and `fuse_rd` at that index is 0, it raises `burn_stb` for one cycle, with `burn_idx` equal to the bit index. This happens on the clock edge that consumes the serial edge.
- R6: In a burning write, no strobe is issued for a written 0 or for a fuse bit that already reads 1.
- R7: Operation code 11 (readback) overwrites the working register with `fuse_rd` at startup. `ser_dout` shows bit 0 first and moves to the next bit after each rising `ser_clk` edge. It reads 0 once all 52 bits are out, and serial input data is ignored.
- R8: `offset_eff` is the XOR of bits 7:0, 21:14 and 35:28. `mode_eff` is the XOR of bits 11:8, 25:22 and 39:36. `errmask_eff` is the XOR of bits 13:12, 27:26 and 41:40.
- R9: `crc_seed` is bits 45:42 and `factory_bits` is bits 47:46.
- R10: The test nibble is bits 51:48. Values 1000, 1001 and 1010 set `test_active` and put 0, 1 or 2 on `test_sel`. Any other value gives `test_active` 0 and `test_sel` 0.
- R11: Operation code 00 in programming mode leaves the working register at zero, whatever serial traffic arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| prog_pin | input | 1 | Programming request, sampled at startup |
| op_sel | input | 2 | Programming operation, sampled at startup |
| ser_clk | input | 1 | Serial bit clock, synchronous to clk |
| ser_din | input | 1 | Serial data in |
| fuse_rd | input | 52 | Present fuse contents |
| burn_stb | output | 1 | One-cycle fuse burn request |
| burn_idx | output | 6 | Fuse index for burn_stb |
| ser_dout | output | 1 | Serial readback data |
| offset_eff | output | 8 | Effective zero offset |
| mode_eff | output | 4 | Effective mode nibble |
| errmask_eff | output | 2 | Effective error mask |
| crc_seed | output | 4 | CRC start value |
| factory_bits | output | 2 | Factory bits |
| test_active | output | 1 | A valid test mode is selected |
| test_sel | output | 2 | Selected test mode number |

## Verification
The hardest behaviour to reach is burn suppression. It needs a burning write in which the written data and the existing fuse pattern cross in all four combinations within one word. The stimulus uses a fuse image and a data word that are partly complementary. It then checks strobe presence and index after every single serial edge. The startup lock is exercised by inverting `prog_pin` and `op_sel` right after startup in every scenario. The test decode is exercised by repeating a temporary write with each distinct test nibble.

// File: rtl/xor3_cfg_store.sv
module xor3_cfg_store (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_pin,
  input  logic [1:0]  op_sel,
  input  logic        ser_clk,
  input  logic        ser_din,
  input  logic [51:0] fuse_rd,
  output logic        burn_stb,
  output logic [5:0]  burn_idx,
  output logic        ser_dout,
  output logic [7:0]  offset_eff,
  output logic [3:0]  mode_eff,
  output logic [1:0]  errmask_eff,
  output logic [3:0]  crc_seed,
  output logic [1:0]  factory_bits,
  output logic        test_active,
  output logic [1:0]  test_sel
);
  localparam int WBITS = 52;
  localparam int CW = $clog2(WBITS + 1);
  localparam logic [CW-1:0] LAST = CW'(WBITS);
  localparam logic [1:0] OP_NONE = 2'b00, OP_WRRAM = 2'b01, OP_WRROM = 2'b10, OP_RDROM = 2'b11;

  logic             started, prog_mode, sclk_q;
  logic [1:0]       op;
  logic [WBITS-1:0] ram;
  logic [CW-1:0]    cnt;
  logic             rise, active;

  assign rise   = ser_clk & ~sclk_q;
  assign active = started & prog_mode & rise & (cnt < LAST) & (op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started   <= 1'b0;
      prog_mode <= 1'b0;
      op        <= OP_NONE;
      ram       <= '0;
      cnt       <= '0;
      sclk_q    <= 1'b0;
      burn_stb  <= 1'b0;
      burn_idx  <= '0;
    end else begin
      sclk_q   <= ser_clk;
      burn_stb <= 1'b0;
      if (!started) begin
        started   <= 1'b1;
        prog_mode <= prog_pin;
        op        <= prog_pin ? op_sel : OP_NONE;
        if (!prog_pin || op_sel == OP_RDROM) ram <= fuse_rd;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (op == OP_WRRAM || op == OP_WRROM) ram[cnt] <= ser_din;
        if (op == OP_WRROM) begin
          burn_stb <= ser_din & ~fuse_rd[cnt];
          burn_idx <= cnt;
        end
      end
    end
  end

  assign ser_dout = (prog_mode && op == OP_RDROM && cnt < LAST) ? ram[cnt] : 1'b0;

  assign offset_eff   = ram[7:0]   ^ ram[21:14] ^ ram[35:28];
  assign mode_eff     = ram[11:8]  ^ ram[25:22] ^ ram[39:36];
  assign errmask_eff  = ram[13:12] ^ ram[27:26] ^ ram[41:40];
  assign crc_seed     = ram[45:42];
  assign factory_bits = ram[47:46];
  assign test_active  = ram[51] & (ram[50:48] <= 3'd2);
  assign test_sel     = test_active ? ram[49:48] : 2'b00;

  p_mode_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> ($stable(prog_mode) && $stable(op)));
  p_normal_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !prog_mode) |=> $stable(ram));
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  p_burn_rom_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burn_stb |-> (prog_mode && op == OP_WRROM));
  p_read_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && op == OP_RDROM) |=> $stable(ram));
  p_idle_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (started && prog_mode && op == OP_NONE) |=> $stable(ram));
endmodule

// File: tb/xor3_cfg_store_tb.sv
module xor3_cfg_store_tb;
  logic clk = 0, rst_n = 0, prog_pin = 0, ser_clk = 0, ser_din = 0;
  logic [1:0] op_sel = 0;
  logic [51:0] fuse_rd = '0;
  logic burn_stb, ser_dout, test_active;
  logic [5:0] burn_idx;
  logic [7:0] offset_eff;
  logic [3:0] mode_eff, crc_seed;
  logic [1:0] errmask_eff, factory_bits, test_sel;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  xor3_cfg_store u_dut (.clk, .rst_n, .prog_pin, .op_sel, .ser_clk, .ser_din, .fuse_rd,
    .burn_stb, .burn_idx, .ser_dout, .offset_eff, .mode_eff, .errmask_eff, .crc_seed,
    .factory_bits, .test_active, .test_sel);

  function automatic logic [22:0] dec(input logic [51:0] w);
    logic [7:0] o; logic [3:0] m; logic [1:0] e; logic ta; logic [1:0] ts;
    o = w[7:0] ^ w[21:14] ^ w[35:28];
    m = w[11:8] ^ w[25:22] ^ w[39:36];
    e = w[13:12] ^ w[27:26] ^ w[41:40];
    ta = (w[51:48] == 4'b1000) || (w[51:48] == 4'b1001) || (w[51:48] == 4'b1010);
    ts = ta ? w[49:48] : 2'b00;
    return {o, m, e, w[45:42], w[47:46], ta, ts};
  endfunction

  function automatic logic [22:0] outs();
    return {offset_eff, mode_eff, errmask_eff, crc_seed, factory_bits, test_active, test_sel};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic boot(input logic p, input logic [1:0] o, input logic [51:0] f);
    @(negedge clk);
    rst_n = 0; prog_pin = p; op_sel = o; fuse_rd = f; ser_clk = 0; ser_din = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    prog_pin = ~p; op_sel = ~o;
  endtask

  task automatic pulse(input logic b, output logic stb, output logic [5:0] idx);
    ser_din = b; ser_clk = 1;
    @(negedge clk);
    stb = burn_stb; idx = burn_idx;
    ser_clk = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 0; fuse_rd = '1;
    @(negedge clk);
    chk("R1 reset outputs", {burn_stb, ser_dout, outs()}, '0);
  endtask

  task automatic t_normal();
    logic [51:0] f = 52'hA_5C_3F_0E_96_1D_B7;
    logic s; logic [5:0] ix; int nb = 0;
    boot(1'b0, 2'b01, f);
    chk("R2 fuse load decode", outs(), dec(f));
    for (int i = 0; i < 52; i++) begin pulse(~f[i], s, ix); nb += s; end
    chk("R2 no strobes normal", nb, 0);
    chk("R2 serial ignored", outs(), dec(f));
  endtask

  task automatic t_wrram();
    logic [51:0] w = 52'h9_2B_71_E4_C8_5A_63;
    logic s; logic [5:0] ix; int nb = 0;
    boot(1'b1, 2'b01, '1);
    for (int i = 0; i < 52; i++) begin pulse(w[i], s, ix); nb += s; end
    chk("R4 no strobe temp write", nb, 0);
    chk("R3 R8 R9 word stored LSB first", outs(), dec(w));
    for (int i = 0; i < 6; i++) pulse(~w[i], s, ix);
    chk("R3 extra edges ignored", outs(), dec(w));
    chk("R1 op locked despite pin change", ser_dout, 0);
  endtask

  task automatic t_wrrom();
    logic [51:0] f = 52'h0_F0_F0_33_CC_0F_55;
    logic [51:0] w = 52'h5_FF_0F_3C_A5_F0_5A;
    logic s; logic [5:0] ix; int miss = 0, burns = 0, exp_b = 0;
    boot(1'b1, 2'b10, f);
    for (int i = 0; i < 52; i++) begin
      logic e;
      e = w[i] & ~f[i];
      exp_b += e;
      pulse(w[i], s, ix);
      burns += s;
      if (s !== e || (e && ix !== 6'(i))) begin
        miss++;
        $display("FAIL R5 R6 bit %0d actual stb=%0b idx=%0d expected stb=%0b idx=%0d", i, s, ix, e, i);
      end
    end
    tests++; if (miss != 0) fails++;
    chk("R5 strobe count", burns, exp_b);
    chk("R5 ram updated", outs(), dec(w));
  endtask

  task automatic t_rdrom();
    logic [51:0] f = 52'h6_3A_D1_0B_7E_94_C2;
    logic s; logic [5:0] ix; int miss = 0;
    boot(1'b1, 2'b11, f);
    chk("R7 ram overwritten by fuses", outs(), dec(f));
    for (int i = 0; i < 52; i++) begin
      if (ser_dout !== f[i]) begin
        miss++;
        $display("FAIL R7 bit %0d actual=%0b expected=%0b", i, ser_dout, f[i]);
      end
      pulse(~f[i], s, ix);
    end
    tests++; if (miss != 0) fails++;
    chk("R7 dout after last bit", ser_dout, 0);
    chk("R7 data input ignored", outs(), dec(f));
  endtask

  task automatic t_idle();
    logic s; logic [5:0] ix; int nb = 0;
    boot(1'b1, 2'b00, '1);
    for (int i = 0; i < 20; i++) begin pulse(1'b1, s, ix); nb += s; end
    chk("R11 idle register zero", outs(), dec('0));
    chk("R11 idle no strobes", nb, 0);
  endtask

  task automatic t_test(input logic [3:0] tv);
    logic [51:0] w;
    logic s; logic [5:0] ix;
    w = {tv, 48'h1_23_45_67_89_AB};
    boot(1'b1, 2'b01, '0);
    for (int i = 0; i < 52; i++) pulse(w[i], s, ix);
    chk($sformatf("R10 test nibble %b", tv), {test_active, test_sel}, dec(w) & 23'h7);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_wrram();
    t_wrrom();
    t_rdrom();
    t_idle();
    t_test(4'b0101);
    t_test(4'b1000);
    t_test(4'b1001);
    t_test(4'b1010);
    t_test(4'b1011);
    t_test(4'b1111);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule